// File: doc/BRIEF.md
# SPI Word Buffer and Event Controller

This block sits between a simple register port and a serial shift engine. A processor writes words into a transmit queue and reads received words out of a receive queue. The shift engine takes transmit words over a valid/ready handshake and delivers received words with a one-cycle valid strobe. Both queues hold eight words by default. Each queue has its own programmable threshold and its own flush control.

The thresholds drive three things: the DMA request levels, a sticky receive-complete event, and a live threshold-reached flag. The block also records a receive overrun when a word arrives for a full receive queue; that word is lost. A sticky transmit-complete event marks the point where the transmit queue has drained and the engine is idle. Five interrupt causes, each with its own enable, are ORed onto a single interrupt line. The three sticky causes share one address with the status view and are cleared by writing ones to them.

Register map, selected by `reg_addr_i`:
- 0 is queue control.
- 1 is status.
- 2 is interrupt enable.
- 3 is interrupt status, which is also the write-one-to-clear register.
- 4 is the data port.

Register writes take effect at the clock edge. Read data is combinational from the address. A read strobe on the data address pops the receive queue at that edge.

Top module: `spi_buf_ctrl`

## Requirements
- R1: After reset the outputs and registers are as follows. Status reads 0x004. Interrupt status reads 0x004. Queue control reads 0x001, which is RX threshold 1 and TX threshold 0. `irq_o` is 0, `tx_dma_req_o` is 1 and `rx_dma_req_o` is 0.
- R2: Words written to address 4 are offered to the shift engine in write order on `eng_tx_data_o`, with `eng_tx_valid_o` high while the TX queue is not empty. A write to a full TX queue (8 words) is ignored. Status bit 1 reads 1 while the TX queue is full.
- R3: A read strobe at address 4 returns the oldest received word and removes it. A read of an empty RX queue returns 0 and changes nothing. Status bit 0 reads 1 while the RX queue is not empty.
- R4: A word that arrives while the RX queue already holds 8 words is dropped. It sets interrupt status bit 0, and that bit stays set until a 1 is written to bit 0 of address 3.
- R5: Interrupt status bit 3 is set one cycle after the RX level changes from below the RX threshold to at or above it. Writing 1 to bit 3 clears it, and it does not set again until the next such transition. Bit 9 reads 1 while the RX level is at or above the threshold.
- R6: `rx_dma_req_o` is high while the RX level is at or above the RX threshold. `tx_dma_req_o` is high while the TX level is at or below the TX threshold. Interrupt status bits 1 and 2 mirror these two requests, in that order.
- R7: In a write to address 0, bit 4 set to 1 empties the RX queue and bit 12 set to 1 empties the TX queue. The other queue is unaffected. The flush bits read back as 0.
- R8: Interrupt status bit 4 is set one cycle after the condition "TX queue empty and `eng_busy_i` low" becomes true. Writing 1 to bit 4 clears it.
- R9: `irq_o` is the OR over bits 4:0 of interrupt status ANDed with the interrupt-enable register at address 2. The enable bits are 0 overrun, 1 RX request, 2 TX request, 3 RX complete and 4 TX complete.
- R10: Queue control holds the RX threshold in bits 3:0 and the TX threshold in bits 11:8. Status bit 7 (busy) reads 1 while `eng_busy_i` is high or the TX queue is not empty. Status bit 2 reads 1 while the TX queue is empty, and bit 3 reads 1 while the RX queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops RX at address 4) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| eng_tx_valid_o | output | 1 | TX word available to the shift engine |
| eng_tx_data_o | output | DW | Oldest TX word |
| eng_tx_ready_i | input | 1 | Shift engine takes the TX word |
| eng_rx_valid_i | input | 1 | Shift engine delivers a received word |
| eng_rx_data_i | input | DW | Received word |
| eng_busy_i | input | 1 | Shift engine is mid-transfer |
| irq_o | output | 1 | Combined interrupt |
| tx_dma_req_o | output | 1 | TX DMA request level |
| rx_dma_req_o | output | 1 | RX DMA request level |

## Verification
On every cycle the assertions check four things. Queue occupancy never exceeds the depth. A pop on an empty queue leaves it unchanged. An arrival into a full RX queue always raises the overrun cause. An RX flush always leaves the queue empty. They also check that the RX complete and TX complete causes follow their threshold and idle transitions, and that an RX request never appears on an empty queue when the threshold is nonzero. Only the bench scenarios can show the things that depend on data and history. These are the word order through both queues, the loss of exactly the word that overran, and a zero return from an empty pop. They also include the DMA level crossing at particular threshold settings, and the way write-one-to-clear interacts with a level that stays above threshold.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    A_FCTL  = 3'd0,
    A_STAT  = 3'd1,
    A_IEN   = 3'd2,
    A_ISTAT = 3'd3,
    A_DATA  = 3'd4
  } reg_addr_e;

  localparam int RX_THR_LSB  = 0;
  localparam int RX_FLUSH    = 4;
  localparam int TX_THR_LSB  = 8;
  localparam int TX_FLUSH    = 12;

  localparam int IRQ_N   = 5;
  localparam int C_OVR   = 0;
  localparam int C_RXREQ = 1;
  localparam int C_TXREQ = 2;
  localparam int C_RXC   = 3;
  localparam int C_TXC   = 4;
  localparam int C_RXLVL = 9;
endpackage

// File: rtl/spi_sfifo.sv
module spi_sfifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem[rd_ptr];
  assign level_o = cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CW'(DEPTH));

  // R3
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !flush_i) |=> empty_o);
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_buf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ovr_evt_i,
  input  logic             rx_ge_i,
  input  logic             tx_req_i,
  input  logic             tx_idle_i,
  input  logic             en_we_i,
  input  logic             clr_we_i,
  input  logic [IRQ_N-1:0] wdata_i,
  output logic [IRQ_N-1:0] cause_o,
  output logic [IRQ_N-1:0] en_o,
  output logic             irq_o
);
  logic ovr_q, rxc_q, txc_q, rx_ge_q, tx_idle_q;
  logic rxc_evt, txc_evt;

  assign rxc_evt = rx_ge_i && !rx_ge_q;
  assign txc_evt = tx_idle_i && !tx_idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q     <= 1'b0;
      rxc_q     <= 1'b0;
      txc_q     <= 1'b0;
      rx_ge_q   <= 1'b0;
      tx_idle_q <= 1'b1;
      en_o      <= '0;
    end else begin
      rx_ge_q   <= rx_ge_i;
      tx_idle_q <= tx_idle_i;
      if (en_we_i) en_o <= wdata_i;
      // set wins over a same-cycle clear
      ovr_q <= ovr_evt_i || (ovr_q && !(clr_we_i && wdata_i[C_OVR]));
      rxc_q <= rxc_evt   || (rxc_q && !(clr_we_i && wdata_i[C_RXC]));
      txc_q <= txc_evt   || (txc_q && !(clr_we_i && wdata_i[C_TXC]));
    end
  end

  always_comb begin
    cause_o          = '0;
    cause_o[C_OVR]   = ovr_q;
    cause_o[C_RXREQ] = rx_ge_i;
    cause_o[C_TXREQ] = tx_req_i;
    cause_o[C_RXC]   = rxc_q;
    cause_o[C_TXC]   = txc_q;
  end

  assign irq_o = |(cause_o & en_o);

  // R5
  rxc_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ge_i) |=> cause_o[C_RXC]);

  // R8
  txc_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_idle_i) |=> cause_o[C_TXC]);
endmodule

// File: rtl/spi_buf_ctrl.sv
module spi_buf_ctrl
  import spi_buf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int THR_W = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             eng_tx_valid_o,
  output logic [DW-1:0]    eng_tx_data_o,
  input  logic             eng_tx_ready_i,
  input  logic             eng_rx_valid_i,
  input  logic [DW-1:0]    eng_rx_data_i,
  input  logic             eng_busy_i,
  output logic             irq_o,
  output logic             tx_dma_req_o,
  output logic             rx_dma_req_o
);
  logic [THR_W-1:0] rx_thr, tx_thr;
  logic             wr_fctl, rx_flush, tx_flush, tx_push, rx_pop;
  logic [DW-1:0]    rx_head;
  logic [CW-1:0]    tx_lvl, rx_lvl;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             ovr_evt, rx_ge, tx_le, tx_idle;
  logic [IRQ_N-1:0] cause, irq_en;

  assign wr_fctl  = reg_wr_i && (reg_addr_i == A_FCTL);
  assign rx_flush = wr_fctl && reg_wdata_i[RX_FLUSH];
  assign tx_flush = wr_fctl && reg_wdata_i[TX_FLUSH];
  assign tx_push  = reg_wr_i && (reg_addr_i == A_DATA);
  assign rx_pop   = reg_rd_i && (reg_addr_i == A_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_thr <= THR_W'(1);
      tx_thr <= '0;
    end else if (wr_fctl) begin
      rx_thr <= reg_wdata_i[RX_THR_LSB +: THR_W];
      tx_thr <= reg_wdata_i[TX_THR_LSB +: THR_W];
    end
  end

  spi_sfifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (tx_flush),
    .push_i  (tx_push),
    .wdata_i (reg_wdata_i[DW-1:0]),
    .pop_i   (eng_tx_ready_i),
    .rdata_o (eng_tx_data_o),
    .level_o (tx_lvl),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  spi_sfifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rx_flush),
    .push_i  (eng_rx_valid_i),
    .wdata_i (eng_rx_data_i),
    .pop_i   (rx_pop),
    .rdata_o (rx_head),
    .level_o (rx_lvl),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  assign eng_tx_valid_o = !tx_empty;
  assign ovr_evt        = eng_rx_valid_i && rx_full;
  assign rx_ge          = 32'(rx_lvl) >= 32'(rx_thr);
  assign tx_le          = 32'(tx_lvl) <= 32'(tx_thr);
  assign tx_idle        = tx_empty && !eng_busy_i;
  assign rx_dma_req_o   = rx_ge;
  assign tx_dma_req_o   = tx_le;

  spi_irq_ctrl u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovr_evt_i (ovr_evt),
    .rx_ge_i   (rx_ge),
    .tx_req_i  (tx_le),
    .tx_idle_i (tx_idle),
    .en_we_i   (reg_wr_i && (reg_addr_i == A_IEN)),
    .clr_we_i  (reg_wr_i && (reg_addr_i == A_ISTAT)),
    .wdata_i   (reg_wdata_i[IRQ_N-1:0]),
    .cause_o   (cause),
    .en_o      (irq_en),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_FCTL: begin
        reg_rdata_o[RX_THR_LSB +: THR_W] = rx_thr;
        reg_rdata_o[TX_THR_LSB +: THR_W] = tx_thr;
      end
      A_STAT: begin
        reg_rdata_o[0] = !rx_empty;
        reg_rdata_o[1] = tx_full;
        reg_rdata_o[2] = tx_empty;
        reg_rdata_o[3] = rx_full;
        reg_rdata_o[7] = eng_busy_i || !tx_empty;
      end
      A_IEN:   reg_rdata_o[IRQ_N-1:0] = irq_en;
      A_ISTAT: begin
        reg_rdata_o[IRQ_N-1:0] = cause;
        reg_rdata_o[C_RXLVL]   = rx_ge;
      end
      A_DATA:  reg_rdata_o = rx_empty ? '0 : REG_W'(rx_head);
      default: reg_rdata_o = '0;
    endcase
  end

  // R4
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_rx_valid_i && rx_full) |=> cause[C_OVR]);

  // R6
  rx_req_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_thr != '0 && rx_empty) |-> !rx_dma_req_o);

  // R7
  rx_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush |=> rx_empty);
endmodule

// File: tb/tb_spi_buf_ctrl.sv
`timescale 1ns/1ps
module tb_spi_buf_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic        rx_valid = 1'b0, busy = 1'b0;
  logic [31:0] rx_data = '0;
  logic        irq, tx_req, rx_req;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  spi_buf_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .eng_tx_valid_o(tx_valid), .eng_tx_data_o(tx_data), .eng_tx_ready_i(tx_ready),
    .eng_rx_valid_i(rx_valid), .eng_rx_data_i(rx_data), .eng_busy_i(busy),
    .irq_o(irq), .tx_dma_req_o(tx_req), .rx_dma_req_o(rx_req)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = (a == 3'd4);
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rx_in(logic [31:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd1, v); chk("R1 status", v, 32'h4);
    rd(3'd3, v); chk("R1 istat", v, 32'h4);
    rd(3'd0, v); chk("R1 fctl", v, 32'h1);
    chk("R1 irq", irq, 0);
    chk("R1 tx_req", tx_req, 1);
    chk("R1 rx_req", rx_req, 0);
  endtask

  task automatic t_tx_order();
    logic [31:0] v;
    wr(3'd0, 32'h201);
    wr(3'd3, 32'h19);
    for (int i = 0; i < 9; i++) wr(3'd4, 32'hA0 + i);
    rd(3'd1, v);
    chk("R2 tx_full", v[1], 1);
    chk("R10 busy", v[7], 1);
    chk("R6 tx_req_high_level", tx_req, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R2 tx_valid", tx_valid, 1);
      chk("R2 tx_order", tx_data, 32'hA0 + i);
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
      if (i == 4) chk("R6 tx_req_lvl3", tx_req, 0);
      if (i == 5) chk("R6 tx_req_lvl2", tx_req, 1);
    end
    chk("R2 ninth_dropped", tx_valid, 0);
    idle(2);
    rd(3'd3, v); chk("R8 txc_set", v[4], 1);
    wr(3'd3, 32'h10);
    rd(3'd3, v); chk("R8 txc_clear", v[4], 0);
  endtask

  task automatic t_rx_thresh();
    logic [31:0] v;
    wr(3'd0, 32'h003);
    wr(3'd3, 32'h19);
    rx_in(32'h11); rx_in(32'h22);
    idle(2);
    chk("R6 rx_req_below", rx_req, 0);
    rd(3'd3, v);
    chk("R5 lvl_below", v[9], 0);
    chk("R5 rxc_below", v[3], 0);
    rx_in(32'h33);
    idle(2);
    chk("R6 rx_req_at", rx_req, 1);
    rd(3'd3, v);
    chk("R5 lvl_at", v[9], 1);
    chk("R5 rxc_at", v[3], 1);
    wr(3'd2, 32'h08);
    chk("R9 irq_rxc", irq, 1);
    wr(3'd3, 32'h08);
    idle(2);
    rd(3'd3, v); chk("R5 rxc_cleared", v[3], 0);
    chk("R9 irq_after_clear", irq, 0);
    rd(3'd4, v); chk("R3 pop0", v, 32'h11);
    rd(3'd4, v); chk("R3 pop1", v, 32'h22);
    rd(3'd4, v); chk("R3 pop2", v, 32'h33);
    rd(3'd4, v); chk("R3 pop_empty", v, 0);
    rd(3'd1, v); chk("R3 rx_nempty", v[0], 0);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    wr(3'd0, 32'h001);
    wr(3'd3, 32'h19);
    for (int i = 0; i < 9; i++) rx_in(32'h50 + i);
    rd(3'd1, v); chk("R10 rx_full", v[3], 1);
    rd(3'd3, v); chk("R4 ovr_set", v[0], 1);
    wr(3'd2, 32'h01);
    chk("R9 irq_ovr", irq, 1);
    for (int i = 0; i < 8; i++) begin
      rd(3'd4, v); chk("R4 kept_word", v, 32'h50 + i);
    end
    rd(3'd4, v); chk("R4 ninth_lost", v, 0);
    rd(3'd3, v); chk("R4 ovr_sticky", v[0], 1);
    wr(3'd3, 32'h01);
    rd(3'd3, v); chk("R4 ovr_clear", v[0], 0);
    chk("R9 irq_off", irq, 0);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    for (int i = 0; i < 3; i++) wr(3'd4, 32'h70 + i);
    rx_in(32'h81); rx_in(32'h82);
    rd(3'd1, v);
    chk("R7 pre_rx", v[0], 1);
    chk("R7 pre_tx", v[2], 0);
    wr(3'd0, 32'h011);
    rd(3'd1, v);
    chk("R7 rx_flushed", v[0], 0);
    chk("R7 tx_kept", v[2], 0);
    rd(3'd0, v); chk("R7 flush_readback", v, 32'h001);
    chk("R7 tx_head", tx_data, 32'h70);
    wr(3'd0, 32'h1001);
    rd(3'd1, v); chk("R7 tx_flushed", v[2], 1);
  endtask

  task automatic t_busy_fields();
    logic [31:0] v;
    busy = 1'b1;
    rd(3'd1, v); chk("R10 busy_in", v[7], 1);
    busy = 1'b0;
    rd(3'd1, v); chk("R10 busy_off", v[7], 0);
    wr(3'd0, 32'hF0A);
    rd(3'd0, v); chk("R10 fctl_fields", v, 32'hF0A);
    chk("R6 tx_req_thr15", tx_req, 1);
    chk("R6 rx_req_thr10", rx_req, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_tx_order();
    t_rx_thresh();
    t_overrun();
    t_flush();
    t_busy_fields();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule